// File: doc/BRIEF.md
# Segment Descriptor Fetch and Address Translation

This block turns a segmented address into a flat 32-bit linear address. It takes a 16-bit segment selector and a 32-bit effective offset. The selector picks one of two descriptor tables, global or local, and gives an index into it. The block then reads the 8-byte descriptor as two 32-bit words over a simple read port.

The descriptor scatters its base address over three fields and its limit over two. The block puts both back together and scales the limit when the granularity flag asks for 4 KB units. It then checks that the segment is present and that the offset lies within bounds. Only when both checks pass does it add the base to the offset.

Each request ends with a one-cycle done pulse. That pulse carries the linear address or a fault code, together with the descriptor's privilege level and the privilege level requested by the selector. Privilege enforcement, descriptor caching, gates and accessed-bit writeback are left to other logic.

Top module: `seg_xlate`

## Requirements
- R1: Selector bit 2 picks the table: 0 uses `gdt_base`, 1 uses `ldt_base`. Selector bits 15:3 are the index. The descriptor address is table base + index×8. The first read is at that address and the second at that address + 4, and there are exactly two reads per request.
- R2: While `rd_valid` is high and `rd_ready` is low, the next cycle keeps `rd_valid` high and `rd_addr` unchanged. A word is taken from `rd_data` only in a cycle where both are high.
- R3: A request that selects the global table with index 0 ends with fault code 1 (null). It makes no read, and `done` rises in the cycle after the one in which `start` was accepted.
- R4: The segment base is rebuilt from three fields: first-word bits 31:16 give base bits 15:0, second-word bits 7:0 give base bits 23:16, and second-word bits 31:24 give base bits 31:24.
- R5: The 20-bit limit comes from first-word bits 15:0 (low part) and second-word bits 19:16 (high part). When second-word bit 23 is 1, the effective limit is (limit<<12)|0xFFF. When it is 0, the effective limit is the limit itself.
- R6: An offset equal to the effective limit is legal. An offset above it ends with fault code 3 (limit).
- R7: When second-word bit 15 (present) is 0, the request ends with fault code 2 (not present). This holds even when the offset is out of bounds.
- R8: On a fault-free request, `lin_addr` = base + offset modulo 2^32 during the done cycle. On any fault, and outside the done cycle, `lin_addr` is 0 and `fault` is 0 outside the done cycle. `done` is high for exactly one cycle per request.
- R9: During the done cycle, `rpl` shows selector bits 1:0 and `dpl` shows second-word bits 14:13. `dpl` is 0 on a null fault.
- R10: A `start` pulse while a request is in progress is ignored. The running request completes with its own selector and offset, and it makes no extra reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a translation (accepted when idle) |
| sel | input | 16 | Segment selector |
| offset | input | 32 | Effective offset within the segment |
| gdt_base | input | 32 | Global descriptor table base address |
| ldt_base | input | 32 | Local descriptor table base address |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 32 | Read word address |
| rd_ready | input | 1 | Read accepted; `rd_data` valid this cycle |
| rd_data | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 0 none, 1 null, 2 not present, 3 limit |
| lin_addr | output | 32 | Linear address (0 unless fault-free done) |
| dpl | output | 2 | Descriptor privilege level at done |
| rpl | output | 2 | Requested privilege level at done |

## Verification
The assertions check the following on every cycle:
- the read request stays steady while it is stalled;
- `done` is a single-cycle pulse that never overlaps a read;
- the outputs stay quiet away from done;
- a faulted result carries no address;
- a null selector completes at once.

The field reassembly, the granularity scaling, the exact boundary at the effective limit, the not-present-over-limit priority and the wrap-around of the address sum are value-dependent. Only the bench scenarios can show these, comparing against descriptors it wrote itself. The bench applies random stalls to the read port, which exercises both read words under back-pressure.

// File: rtl/seg_xlate.sv
module seg_xlate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] sel,
  input  logic [31:0] offset,
  input  logic [31:0] gdt_base,
  input  logic [31:0] ldt_base,
  output logic        rd_valid,
  output logic [31:0] rd_addr,
  input  logic        rd_ready,
  input  logic [31:0] rd_data,
  output logic        done,
  output logic [1:0]  fault,
  output logic [31:0] lin_addr,
  output logic [1:0]  dpl,
  output logic [1:0]  rpl
);
  localparam logic [1:0] S_IDLE = 2'd0, S_LO = 2'd1, S_HI = 2'd2, S_FIN = 2'd3;
  localparam logic [1:0] F_NONE = 2'd0, F_NULL = 2'd1, F_NP = 2'd2, F_LIM = 2'd3;

  logic [1:0]  st;
  logic [15:0] sel_q;
  logic [31:0] off_q, dadr_q, lo_q, hi_q;
  logic        null_q;
  logic        busy;

  wire        is_null = !sel[2] && (sel[15:3] == 13'd0);
  wire [31:0] tbase   = sel[2] ? ldt_base : gdt_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sel_q  <= '0;
      off_q  <= '0;
      dadr_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      null_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          sel_q  <= sel;
          off_q  <= offset;
          dadr_q <= tbase + {16'd0, sel[15:3], 3'd0};
          null_q <= is_null;
          st     <= is_null ? S_FIN : S_LO;
        end
        S_LO: if (rd_ready) begin
          lo_q <= rd_data;
          st   <= S_HI;
        end
        S_HI: if (rd_ready) begin
          hi_q <= rd_data;
          st   <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign rd_valid = (st == S_LO) || (st == S_HI);
  assign rd_addr  = (st == S_HI) ? dadr_q + 32'd4 : dadr_q;

  wire [31:0] seg_base = {hi_q[31:24], hi_q[7:0], lo_q[31:16]};
  wire [19:0] raw_lim  = {hi_q[19:16], lo_q[15:0]};
  wire [31:0] eff_lim  = hi_q[23] ? {raw_lim, 12'hFFF} : {12'd0, raw_lim};

  logic [1:0] fcode;
  always_comb begin
    if (null_q)            fcode = F_NULL;
    else if (!hi_q[15])    fcode = F_NP;
    else if (off_q > eff_lim) fcode = F_LIM;
    else                   fcode = F_NONE;
  end

  assign done     = (st == S_FIN);
  assign fault    = done ? fcode : F_NONE;
  assign lin_addr = (done && fcode == F_NONE) ? seg_base + off_q : 32'd0;
  assign dpl      = (done && !null_q) ? hi_q[14:13] : 2'd0;
  assign rpl      = done ? sel_q[1:0] : 2'd0;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [15:0] sel,
  input logic        busy,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [31:0] rd_addr,
  input logic        done,
  input logic [1:0]  fault,
  input logic [31:0] lin_addr
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R2
  AST_NULL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !sel[2] && sel[15:3] == 13'd0 |=> done && fault == 2'd1 && !rd_valid); // R3
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault != 2'd0 |-> lin_addr == 32'd0); // R8
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> fault == 2'd0 && lin_addr == 32'd0); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_valid); // R10
endmodule

bind seg_xlate seg_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .busy(busy),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .done(done), .fault(fault), .lin_addr(lin_addr)
);

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] sel = '0;
  logic [31:0] offset = '0, gdt_base = '0, ldt_base = '0;
  logic rd_valid, rd_ready = 1'b0;
  logic [31:0] rd_addr, rd_data = '0;
  logic done;
  logic [1:0] fault, dpl, rpl;
  logic [31:0] lin_addr;

  always #2.5 clk = ~clk;

  seg_xlate u_seg_xlate (.*);

  int total = 0, bad = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rlog [8];
  int nrd = 0;
  bit inject_busy = 0;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] base, input logic [19:0] lim,
                          input bit g, input bit p, input logic [1:0] pl);
    mem[a]      = {base[15:0], lim[15:0]};
    mem[a + 4]  = {base[31:24], g, 1'b1, 1'b0, 1'b0, lim[19:16], p, pl, 1'b1, 4'b0010, base[23:16]};
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid && ($urandom % 4 != 0)) begin
        rd_ready = 1'b1;
        rd_data  = mrd(rd_addr);
        if (nrd < 8) rlog[nrd] = rd_addr;
        nrd++;
      end else begin
        rd_ready = 1'b0;
        rd_data  = $urandom;
      end
    end
  end

  task automatic run(input logic [15:0] s, input logic [31:0] off, input logic [31:0] gb, input logic [31:0] lb);
    logic [31:0] da, lo, hi, base, elim, exp_lin;
    logic [19:0] lim;
    logic [1:0] exp_f, exp_dpl;
    bit nul;
    int cyc;
    nul = !s[2] && s[15:3] == 0;
    da  = (s[2] ? lb : gb) + {16'd0, s[15:3], 3'd0};
    lo  = mrd(da);
    hi  = mrd(da + 4);
    base = {hi[31:24], hi[7:0], lo[31:16]};
    lim  = {hi[19:16], lo[15:0]};
    elim = hi[23] ? ({12'd0, lim} << 12) | 32'hFFF : {12'd0, lim};
    if (nul) exp_f = 1; else if (!hi[15]) exp_f = 2; else if (off > elim) exp_f = 3; else exp_f = 0;
    exp_lin = (exp_f == 0) ? base + off : 32'd0;
    exp_dpl = nul ? 2'd0 : hi[14:13];
    @(negedge clk);
    nrd = 0;
    sel = s; offset = off; gdt_base = gb; ldt_base = lb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      if (inject_busy && cyc == 1) begin
        start = 1'b1; sel = s ^ 16'hFFF8; offset = ~off;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (!done) begin
      chk(0, "R8 timeout", 0, 1);
      return;
    end
    chk(fault == exp_f, nul ? "R3 null fault" : (exp_f == 2 ? "R7 fault" : "R6 fault"), {30'd0, fault}, {30'd0, exp_f});
    chk(lin_addr == exp_lin, "R8 lin_addr (R4 R5)", lin_addr, exp_lin);
    chk(dpl == exp_dpl && rpl == s[1:0], "R9 dpl/rpl", {dpl, rpl}, {exp_dpl, s[1:0]});
    if (nul) chk(nrd == 0, "R3 no reads", nrd, 0);
    else begin
      chk(nrd == 2, inject_busy ? "R10 read count" : "R1 read count", nrd, 2);
      if (nrd == 2) chk(rlog[0] == da && rlog[1] == da + 4, "R1 read addrs", rlog[0], da);
    end
    @(negedge clk);
    chk(!done, "R8 done one cycle", {31'd0, done}, 0);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog R8 actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!done && !rd_valid && fault == 0, "R8 reset state", {done, rd_valid}, 0);
    rst_n = 1'b1;
    // directed corners
    put_desc(32'h1000 + 8*5, 32'h0012_3400, 20'h00FFF, 0, 1, 2'd3);
    run({13'd5, 1'b0, 2'd3}, 32'h0000_0FFF, 32'h1000, 32'h8000); // R6 equal legal
    run({13'd5, 1'b0, 2'd3}, 32'h0000_1000, 32'h1000, 32'h8000); // R6 over
    put_desc(32'h8000 + 0, 32'hFFFF_F000, 20'h00003, 1, 1, 2'd1);
    run({13'd0, 1'b1, 2'd1}, 32'h0000_3FFF, 32'h1000, 32'h8000); // R5 G=1 edge, R8 wrap, R1 LDT idx0
    run({13'd0, 1'b1, 2'd1}, 32'h0000_4000, 32'h1000, 32'h8000); // R5 over
    run({13'd0, 1'b0, 2'd2}, 32'h0, 32'h1000, 32'h8000);          // R3 null
    put_desc(32'h1000 + 8*9, 32'hABCD_1234, 20'h00010, 0, 0, 2'd2);
    run({13'd9, 1'b0, 2'd0}, 32'h0000_0500, 32'h1000, 32'h8000); // R7 priority
    inject_busy = 1;
    run({13'd5, 1'b0, 2'd0}, 32'h0000_0100, 32'h1000, 32'h8000); // R10
    inject_busy = 0;
    // random
    for (int i = 0; i < 80; i++) begin
      logic [31:0] gb, lb, b, off;
      logic [12:0] idx;
      logic [19:0] lm;
      bit ti, g;
      gb = $urandom & 32'hFFFF_FFF0; lb = $urandom & 32'hFFFF_FFF0;
      idx = 13'($urandom); ti = 1'($urandom); g = 1'($urandom);
      b = $urandom; lm = 20'($urandom);
      put_desc((ti ? lb : gb) + {16'd0, idx, 3'd0}, b, lm, g, ($urandom % 6) != 0, 2'($urandom));
      case ($urandom % 3)
        0: off = g ? {lm, 12'hFFF} : {12'd0, lm};
        1: off = (g ? {lm, 12'hFFF} : {12'd0, lm}) + 1;
        default: off = $urandom;
      endcase
      run({idx, ti, 2'($urandom)}, off, gb, lb);
      mem.delete();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule